// File: doc/BRIEF.md
# DMA Transfer Count Register Unit

This block keeps the byte counter that paces a byte-at-a-time DMA transfer. Software programs a starting count through byte-wide registers. It then issues a command byte whose DMA flag is set, which copies that start value into a separate live counter. Each byte the data mover handles pulses a decrement strobe. When the counter reaches zero, a terminal-count flag is raised that software and the data mover can both observe.

The live counter and the start value are held in separate storage. Reading a count address therefore shows the remaining count, while writing it only changes the value for the next transfer. A start value of zero is treated as a full 64 KiB transfer. Until software first writes the top count byte, that address reads back a chip identification byte taken from an input, so driver code can probe which variant is present. A configuration byte and a small status byte complete the register set.

Top module: `dtc_unit`

## Requirements
- R1: After reset the live counter reads 0, `tc_o` is 0, `reg_rdata` is 0 and the configuration byte (address 4) reads 7.
- R2: Writes to count addresses 0 (bits 7:0), 1 (bits 15:8) and 2 (bits 23:16) go to the start value only. Reads of those addresses keep returning the live counter until a reload.
- R3: A write to the command address 3 with bit 7 set, or a pulse on `load_i`, reloads the live counter from the start value. A command with bit 7 clear does not reload.
- R4: When the start value is zero, a reload puts 0x010000 in the live counter.
- R5: Until address 2 has been written once after reset, reading it returns `chip_id_i`. After that write, it returns live counter bits 23:16.
- R6: Each cycle with `dec_i` high and no reload lowers a non-zero counter by exactly one. When the counter is zero, `dec_i` leaves it at zero.
- R7: `tc_o` rises on the same clock edge at which a decrement brings the counter from 1 to 0. It then stays high while the counter sits at zero.
- R8: A command write whose bits 6:0 equal 0x10 (transfer start) clears `tc_o`, unless a decrement reaches zero in the same cycle.
- R9: When a reload and `dec_i` fall in the same cycle, the counter takes the reload value and the decrement is dropped.
- R10: A read pulse returns the addressed byte on `reg_rdata` from the following cycle. Address 3 reads `{7'b0, tc_o}`. Address 4 reads back the last configuration byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data byte |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| dec_i | input | 1 | One byte moved: decrement |
| load_i | input | 1 | Reload live counter from start value |
| chip_id_i | input | 8 | Identification byte for the top count address |
| tc_o | output | 1 | Terminal count reached |

## Verification
Every result is due one clock edge after its stimulus. A register write, a reload or a decrement shows in the counter and in `tc_o` at the next rising edge. A read pulse delivers its byte on `reg_rdata` at the edge it spans. The bench drives each stimulus on a falling edge and releases it on the next falling edge. It then samples `tc_o` and `reg_rdata` right there, one edge after the stimulus. Counter contents are only ever observed through such register reads, so each check lands in the first cycle in which its result is due.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   localparam int unsigned DTC_BYTE_W     = 8;
   localparam int unsigned DTC_DMA_BIT    = 7;
   localparam logic [6:0]  DTC_OP_XFER    = 7'h10;
   localparam logic [7:0]  DTC_CFG_RESET  = 8'h07;
endpackage

// File: rtl/dtc_start_regs.sv
module dtc_start_regs #(
   parameter int unsigned NBYTES = 3,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [7:0]            wr_data,
   output logic [NBYTES*8-1:0]   start_cnt,
   output logic                  top_written
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NBYTES - 1);

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            start_cnt[g*8 +: 8] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(g))
            start_cnt[g*8 +: 8] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         top_written <= 1'b0;
      else if (wr_en && wr_addr == TOP_ADDR)
         top_written <= 1'b1;
   end
endmodule

// File: rtl/dtc_counter.sv
module dtc_counter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             dec,
   input  logic             tc_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             tc
);
   logic step;
   logic hits_zero;

   assign step      = dec && !load && (cnt != '0);
   assign hits_zero = step && (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= reload_val;
      else if (step)
         cnt <= cnt - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tc <= 1'b0;
      else if (hits_zero)
         tc <= 1'b1;
      else if (tc_clr)
         tc <= 1'b0;
   end
endmodule

// File: rtl/dtc_unit.sv
module dtc_unit #(
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned ZERO_LOAD = 32'h0001_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [7:0]        reg_rdata,
   input  logic              dec_i,
   input  logic              load_i,
   input  logic [7:0]        chip_id_i,
   output logic              tc_o
);
   import dtc_pkg::*;

   localparam int unsigned NBYTES = CNT_W / DTC_BYTE_W;
   localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NBYTES);
   localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NBYTES + 1);

   if (CNT_W % DTC_BYTE_W != 0 || CNT_W < 16) begin : g_bad_width
      $error("dtc_unit: CNT_W must be a multiple of 8 and at least 16");
   end
   if ((1 << ADDR_W) < NBYTES + 2) begin : g_bad_addr
      $error("dtc_unit: ADDR_W too small for register map");
   end

   logic [CNT_W-1:0] start_cnt;
   logic [CNT_W-1:0] reload_val;
   logic [CNT_W-1:0] live_cnt;
   logic             top_written;
   logic             cmd_wr;
   logic             load_fire;
   logic             ti_fire;
   logic [7:0]       cfg_q;
   logic [7:0]       rd_next;

   assign cmd_wr     = reg_wr && reg_addr == CMD_ADDR;
   assign load_fire  = load_i || (cmd_wr && reg_wdata[DTC_DMA_BIT]);
   assign ti_fire    = cmd_wr && reg_wdata[6:0] == DTC_OP_XFER;
   assign reload_val = (start_cnt == '0) ? CNT_W'(ZERO_LOAD) : start_cnt;

   dtc_start_regs #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_start (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr),
      .wr_addr     (reg_addr),
      .wr_data     (reg_wdata),
      .start_cnt   (start_cnt),
      .top_written (top_written)
   );

   dtc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_fire),
      .reload_val (reload_val),
      .dec        (dec_i),
      .tc_clr     (ti_fire),
      .cnt        (live_cnt),
      .tc         (tc_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= DTC_CFG_RESET;
      else if (reg_wr && reg_addr == CFG_ADDR)
         cfg_q <= reg_wdata;
   end

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < int'(NBYTES); i++) begin
         if (reg_addr == ADDR_W'(i)) begin
            if (i == int'(NBYTES) - 1 && !top_written)
               rd_next = chip_id_i;
            else
               rd_next = live_cnt[i*8 +: 8];
         end
      end
      if (reg_addr == CMD_ADDR)
         rd_next = {7'b0, tc_o};
      if (reg_addr == CFG_ADDR)
         rd_next = cfg_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_rdata <= '0;
      else if (reg_rd)
         reg_rdata <= rd_next;
   end
endmodule

// File: rtl/dtc_unit_chk.sv
module dtc_unit_chk #(
   parameter int unsigned CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dec_i,
   input logic             load_fire,
   input logic             ti_fire,
   input logic [CNT_W-1:0] live_cnt,
   input logic [CNT_W-1:0] reload_val,
   input logic             tc_o
);
   assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_fire |=> live_cnt == $past(reload_val));

   assert_load_beats_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_fire && dec_i) |=> live_cnt == $past(reload_val));

   assert_dec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_fire && live_cnt != '0) |=> live_cnt == $past(live_cnt) - CNT_W'(1));

   assert_zero_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_fire && live_cnt == '0) |=> live_cnt == '0);

   assert_tc_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_fire && live_cnt == CNT_W'(1)) |=> tc_o);

   assert_tc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ti_fire && !(dec_i && !load_fire && live_cnt == CNT_W'(1))) |=> !tc_o);
endmodule

bind dtc_unit dtc_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dec_i      (dec_i),
   .load_fire  (load_fire),
   .ti_fire    (ti_fire),
   .live_cnt   (live_cnt),
   .reload_val (reload_val),
   .tc_o       (tc_o)
);

// File: tb/dtc_unit_bench.sv
module dtc_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_rdata;
   logic       dec_i = 1'b0;
   logic       load_i = 1'b0;
   logic [7:0] chip_id_i = 8'hA5;
   logic       tc_o;

   int checks = 0;
   int fails  = 0;
   logic [23:0] exp_cnt;

   always #10 clk = ~clk;

   dtc_unit u_dtc_unit (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .dec_i(dec_i), .load_i(load_i), .chip_id_i(chip_id_i), .tc_o(tc_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   task automatic pulse_dec();
      @(negedge clk);
      dec_i = 1'b1;
      @(negedge clk);
      dec_i = 1'b0;
   endtask

   task automatic check_live(input string req, input logic [23:0] exp);
      logic [7:0] b0, b1, b2;
      rd(3'd0, b0); rd(3'd1, b1); rd(3'd2, b2);
      check(req, {8'h0, b2, b1, b0}, {8'h0, exp});
   endtask

   task automatic set_start(input logic [23:0] v);
      wr(3'd0, v[7:0]); wr(3'd1, v[15:8]); wr(3'd2, v[23:16]);
   endtask

   initial begin
      logic [7:0] v;
      logic [23:0] sv;
      repeat (3) @(negedge clk);
      check("R1 rdata after reset", {24'h0, reg_rdata}, 32'h0);
      check("R1 tc after reset", {31'h0, tc_o}, 32'h0);
      rst_n = 1'b1;
      rd(3'd4, v); check("R1 config reset", {24'h0, v}, 32'h7);
      rd(3'd0, v); check("R1 count low reset", {24'h0, v}, 32'h0);
      rd(3'd2, v); check("R5 chip id before write", {24'h0, v}, 32'hA5);
      rd(3'd3, v); check("R10 status reads tc", {24'h0, v}, 32'h0);

      // R2: start writes leave live counter alone; R5 top byte now live
      set_start(24'h123456);
      check_live("R2 live unchanged by start writes", 24'h0);
      wr(3'd3, 8'h10);
      check_live("R3 no reload without DMA flag", 24'h0);
      wr(3'd3, 8'h80);
      check_live("R3 reload from start", 24'h123456);

      // R4 zero start
      set_start(24'h0);
      wr(3'd3, 8'h80);
      check_live("R4 zero start loads 0x10000", 24'h010000);

      // sweep of start values through both load paths
      for (int i = 0; i < 24; i++) begin
         sv = 24'(i * 32'h0B1337 + (i << 20));
         if (i == 1) sv = 24'hFFFFFF;
         if (i == 2) sv = 24'h000001;
         set_start(sv);
         exp_cnt = (sv == 24'h0) ? 24'h010000 : sv;
         if (i % 2 == 0) wr(3'd3, 8'h80 | 8'(i));
         else begin
            @(negedge clk); load_i = 1'b1; @(negedge clk); load_i = 1'b0;
         end
         check_live("R3 R4 sweep reload", exp_cnt);
      end

      // R6/R7 countdown from 4
      set_start(24'd4);
      wr(3'd3, 8'h80);
      check("R8 R3 tc low after load", {31'h0, tc_o}, 32'h0);
      for (int k = 3; k >= 0; k--) begin
         pulse_dec();
         check("R7 tc at terminal", {31'h0, tc_o}, (k == 0) ? 32'h1 : 32'h0);
      end
      check_live("R6 counted to zero", 24'h0);
      pulse_dec();
      check_live("R6 dec at zero ignored", 24'h0);
      check("R7 tc held at zero", {31'h0, tc_o}, 32'h1);
      rd(3'd3, v); check("R10 status shows tc", {24'h0, v}, 32'h1);

      // R8 transfer start clears tc
      wr(3'd3, 8'h10);
      check("R8 transfer cmd clears tc", {31'h0, tc_o}, 32'h0);

      // R9 load beats dec
      set_start(24'd9);
      @(negedge clk); load_i = 1'b1; dec_i = 1'b1;
      @(negedge clk); load_i = 1'b0; dec_i = 1'b0;
      check_live("R9 load wins over dec", 24'd9);
      pulse_dec();
      check_live("R6 single step", 24'd8);

      // R10 config byte
      wr(3'd4, 8'h3C);
      rd(3'd4, v); check("R10 config readback", {24'h0, v}, 32'h3C);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule